// File: doc/BRIEF.md
# Indexed Colour Palette Loader

This block holds a 256-entry colour lookup table with an 8-bit red, green and blue value per entry. Software loads it over a simple 32-bit register bus through a window of 16 bytes. It first writes a start index to the index register. It then streams colour bytes into a single data register. Each data write carries its byte in bits 31:24 of the word.

A small sequencer sets which component the next data byte fills. It has three states: RED (encoding 0), GREEN (1) and BLUE (2). Its transitions are:

- A data write moves RED to GREEN and GREEN to BLUE.
- A data write in BLUE moves back to RED and advances the index by one, modulo 256.
- An index write sends any state to RED.
- Any other cycle holds the state.
- The unused encoding 3 acts exactly like RED, so a corrupted state still loads red and moves on.

The pixel pipeline reads the table through a separate lookup port. It presents an 8-bit pixel index and receives packed RGB. A parameter selects a combinational lookup or one registered cycle of latency. When a write and a lookup touch the same entry in the same cycle, the lookup returns the value from before the write.

Top module: `clut_dac`

## Requirements
- R1: A bus write is accepted only when bus_sel and bus_we are high, all four bus_be bits are set and bus_addr[1:0] is 0. A partial or misaligned write changes no entry, index or state.
- R2: An accepted write at byte offset 0 loads the index from bus_wdata[31:24] and forces the state to RED, even partway through a colour.
- R3: An accepted write at offset 4 stores bus_wdata[31:24] into the red, green or blue part of the current entry, in that order, one component per write.
- R4: After the blue byte is stored, the index becomes index+1 modulo 256 (255 wraps to 0) and the state returns to RED.
- R5: A bus read (bus_sel high, bus_we low) returns zero on bus_rdata and changes neither index nor state.
- R6: Writes at offsets 8 and 12 are ignored.
- R7: After reset, every entry reads 0x000000 except entry 255, which reads 0xFFFFFF. The index is 0 and the state is RED.
- R8: lk_rgb carries {red[23:16], green[15:8], blue[7:0]} of entry lk_idx. With LOOKUP_REG=1 (the default) it appears one clock after lk_idx is sampled. With LOOKUP_REG=0 it follows lk_idx in the same cycle.
- R9: A lookup of an entry in the same cycle as a write to that entry returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_be | input | BUS_W/8 | Byte enables; all must be set for a write |
| bus_wdata | input | BUS_W | Write data, payload in the top byte |
| bus_rdata | output | BUS_W | Read data, always zero |
| lk_idx | input | IDX_W | Pixel index to look up |
| lk_rgb | output | 3*COMP_W | Packed colour of the looked-up entry |

## Verification
A bus write to the data register and a lookup from the pixel side can land on the same entry in the same cycle. The bench provokes this by driving the lookup index to the entry being written by the very write that finishes the colour. It then compares the registered result with the bench model's colour from before that write. The following cycle's lookup of the same entry must show the new colour, so stale data and premature forwarding are both caught.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Component sequencer states; encoding 3 is unused and behaves as CS_RED
    typedef enum logic [1:0] {
        CS_RED   = 2'd0,
        CS_GREEN = 2'd1,
        CS_BLUE  = 2'd2
    } comp_e;

    // Word offsets inside the register window
    localparam int unsigned WORD_INDEX = 0;
    localparam int unsigned WORD_DATA  = 1;

    localparam int unsigned NUM_COMP = 3;

endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W/8-1:0] be,
    input  logic [BUS_W-1:0]  wdata,
    output logic              idx_wr,
    output logic              data_wr,
    output logic [BYTE_W-1:0] payload
);
    import clut_pkg::*;

    localparam int unsigned BE_W     = BUS_W / 8;
    localparam int unsigned WORD_LSB = $clog2(BE_W);
    localparam int unsigned WORD_W   = ADDR_W - WORD_LSB;

    logic              full_word;
    logic              aligned;
    logic              accept;
    logic [WORD_W-1:0] word;
    logic              unused_low;

    always_comb begin
        full_word = &be;
        aligned   = (addr[WORD_LSB-1:0] == '0);
        accept    = sel && we && full_word && aligned;
        word      = addr[ADDR_W-1:WORD_LSB];
        idx_wr    = accept && (word == WORD_W'(WORD_INDEX));
        data_wr   = accept && (word == WORD_W'(WORD_DATA));
        payload   = wdata[BUS_W-1 -: BYTE_W];
    end

    assign unused_low = ^wdata[BUS_W-BYTE_W-1:0];

endmodule

// File: rtl/clut_seq.sv
module clut_seq #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             data_wr,
    input  logic [IDX_W-1:0] new_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic             we_r,
    output logic             we_g,
    output logic             we_b
);
    import clut_pkg::*;

    comp_e            state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CS_RED;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        if (idx_wr) begin
            state_nx = CS_RED;
            idx_nx   = new_idx;
        end else if (data_wr) begin
            unique case (state)
                CS_GREEN: state_nx = CS_BLUE;
                CS_BLUE: begin
                    state_nx = CS_RED;
                    idx_nx   = idx + 1'b1;
                end
                default:  state_nx = CS_GREEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        we_r   = 1'b0;
        we_g   = 1'b0;
        we_b   = 1'b0;
        wr_idx = idx;
        if (data_wr) begin
            unique case (state)
                CS_GREEN: we_g = 1'b1;
                CS_BLUE:  we_b = 1'b1;
                default:  we_r = 1'b1;
            endcase
        end
    end

    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx == $past(new_idx)) && (state == CS_RED));

    p_comp_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && state == CS_RED) |=> state == CS_GREEN);

    p_index_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && state == CS_BLUE) |=>
            (idx == IDX_W'($past(idx) + 1'b1)) && (state == CS_RED));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_wr || data_wr) |=> $stable(idx) && $stable(state));

endmodule

// File: rtl/clut_store.sv
module clut_store #(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned COMP_W     = 8,
    parameter bit          LOOKUP_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [COMP_W-1:0]   wr_val,
    input  logic                we_r,
    input  logic                we_g,
    input  logic                we_b,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [3*COMP_W-1:0] lk_rgb
);
    import clut_pkg::*;

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [NUM_COMP-1:0]   we_v;
    logic [COMP_W-1:0]     rd [NUM_COMP];
    logic [3*COMP_W-1:0]   rd_word;

    assign we_v    = {we_b, we_g, we_r};
    assign rd_word = {rd[0], rd[1], rd[2]};

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
        logic [COMP_W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= (i == DEPTH - 1) ? '1 : '0;
                end
            end else if (we_v[c]) begin
                mem[wr_idx] <= wr_val;
            end
        end

        assign rd[c] = mem[lk_idx];

        p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
            we_v[c] |=> mem[$past(wr_idx)] == $past(wr_val));
    end

    if (LOOKUP_REG) begin : g_reg
        logic [3*COMP_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= rd_word;
        end
        assign lk_rgb = q;
    end else begin : g_comb
        assign lk_rgb = rd_word;
    end

endmodule

// File: rtl/clut_dac.sv
module clut_dac #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned BUS_W      = 32,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned COMP_W     = 8,
    parameter bit          LOOKUP_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W/8-1:0]   bus_be,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [IDX_W-1:0]     lk_idx,
    output logic [3*COMP_W-1:0]  lk_rgb
);
    logic              idx_wr;
    logic              data_wr;
    logic [COMP_W-1:0] payload;
    logic [IDX_W-1:0]  wr_idx;
    logic              we_r, we_g, we_b;

    assign bus_rdata = '0;

    clut_decode #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .BYTE_W (COMP_W)
    ) u_decode (
        .sel     (bus_sel),
        .we      (bus_we),
        .addr    (bus_addr),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .payload (payload)
    );

    clut_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .new_idx (payload[COMP_W-1 -: IDX_W]),
        .wr_idx  (wr_idx),
        .we_r    (we_r),
        .we_g    (we_g),
        .we_b    (we_b)
    );

    clut_store #(
        .IDX_W      (IDX_W),
        .COMP_W     (COMP_W),
        .LOOKUP_REG (LOOKUP_REG)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_idx (wr_idx),
        .wr_val (payload),
        .we_r   (we_r),
        .we_g   (we_g),
        .we_b   (we_b),
        .lk_idx (lk_idx),
        .lk_rgb (lk_rgb)
    );

    p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_r, we_g, we_b}));

endmodule

// File: tb/clut_dac_bench.sv
module clut_dac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_idx = '0;
    logic [23:0] lk_rgb;

    int checks = 0;
    int errors = 0;

    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];
    logic [7:0] m_idx;
    int         m_st;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    clut_dac u_clut_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lk_idx    (lk_idx),
        .lk_rgb    (lk_rgb)
    );

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            mr[i] = (i == 255) ? 8'hFF : 8'h00;
            mg[i] = (i == 255) ? 8'hFF : 8'h00;
            mb[i] = (i == 255) ? 8'hFF : 8'h00;
        end
        m_idx = 8'd0;
        m_st  = 0;
    endtask

    // one bus cycle plus one lookup; pushes the expected lookup result
    task automatic step(input logic s, input logic w, input logic [3:0] a,
                        input logic [3:0] be, input logic [31:0] d,
                        input logic [7:0] li, input string tag);
        @(negedge clk);
        bus_sel   = s;
        bus_we    = w;
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        lk_idx    = li;
        exp_q.push_back({mr[li], mg[li], mb[li]});
        tag_q.push_back(tag);
        if (s && w && be == 4'hF && a[1:0] == 2'b00) begin
            if (a[3:2] == 2'd0) begin
                m_idx = d[31:24];
                m_st  = 0;
            end else if (a[3:2] == 2'd1) begin
                case (m_st)
                    0: begin mr[m_idx] = d[31:24]; m_st = 1; end
                    1: begin mg[m_idx] = d[31:24]; m_st = 2; end
                    default: begin
                        mb[m_idx] = d[31:24];
                        m_idx = m_idx + 8'd1;
                        m_st = 0;
                    end
                endcase
            end
        end
        if (s && !w) begin
            #1;
            checks++;
            if (bus_rdata !== 32'h0) begin
                errors++;
                $display("FAIL R5 read data: got %h expected %h", bus_rdata, 32'h0);
            end
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [7:0] li,
                      input string tag);
        step(1'b1, 1'b1, a, 4'hF, d, li, tag);
    endtask

    task automatic look(input logic [7:0] li, input string tag);
        step(1'b0, 1'b0, 4'h0, 4'h0, 32'h0, li, tag);
    endtask

    // monitor: registered lookup result visible just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (lk_rgb !== e) begin
                    errors++;
                    $display("FAIL %s lookup: got %h expected %h", t, lk_rgb, e);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset contents
        look(8'd255, "R7");
        look(8'd0,   "R7");
        look(8'd128, "R7");

        // R2/R3 basic load, R8 packing
        wr(4'h0, 32'h0A00_0000, 8'd10, "R2");
        wr(4'h4, 32'hAA00_0000, 8'd10, "R3");
        wr(4'h4, 32'hBB12_3456, 8'd10, "R3");
        wr(4'h4, 32'hCC00_00FF, 8'd10, "R3");
        look(8'd10, "R8");
        // R4 auto-increment to 11
        wr(4'h4, 32'h1100_0000, 8'd11, "R4");
        wr(4'h4, 32'h2200_0000, 8'd11, "R4");
        wr(4'h4, 32'h3300_0000, 8'd11, "R4");
        look(8'd11, "R4");
        look(8'd10, "R8");

        // R1/R5/R6 ignored traffic interleaved with a colour load
        wr(4'h0, 32'h1400_0000, 8'd20, "R2");
        wr(4'h4, 32'h0100_0000, 8'd20, "R3");
        wr(4'h8, 32'hEE00_0000, 8'd20, "R6");
        wr(4'hC, 32'hED00_0000, 8'd20, "R6");
        step(1'b1, 1'b1, 4'h4, 4'h7, 32'hDD00_0000, 8'd20, "R1");
        step(1'b1, 1'b1, 4'h0, 4'hE, 32'hDC00_0000, 8'd20, "R1");
        wr(4'h5, 32'hDB00_0000, 8'd20, "R1");
        step(1'b1, 1'b0, 4'h4, 4'h0, 32'hDA00_0000, 8'd20, "R5");
        step(1'b1, 1'b0, 4'h0, 4'hF, 32'hD900_0000, 8'd20, "R5");
        wr(4'h4, 32'h0200_0000, 8'd20, "R1");
        wr(4'h4, 32'h0300_0000, 8'd20, "R6");
        look(8'd20, "R1");
        wr(4'h4, 32'h4400_0000, 8'd21, "R4");
        look(8'd21, "R4");

        // R4 wrap from 255 to 0
        wr(4'h0, 32'hFF00_0000, 8'd255, "R2");
        wr(4'h4, 32'h1000_0000, 8'd255, "R4");
        wr(4'h4, 32'h2000_0000, 8'd255, "R4");
        wr(4'h4, 32'h3000_0000, 8'd255, "R4");
        wr(4'h4, 32'h4000_0000, 8'd0, "R4");
        wr(4'h4, 32'h5000_0000, 8'd0, "R4");
        wr(4'h4, 32'h6000_0000, 8'd0, "R4");
        look(8'd255, "R4");
        look(8'd0,   "R4");

        // R9 same-cycle write and lookup of one entry
        wr(4'h0, 32'h0500_0000, 8'd5, "R9");
        wr(4'h4, 32'h7100_0000, 8'd5, "R9");
        wr(4'h4, 32'h7200_0000, 8'd5, "R9");
        wr(4'h4, 32'h7300_0000, 8'd5, "R9");
        look(8'd5, "R9");

        // R2 index write mid-colour restarts at red
        wr(4'h0, 32'h1E00_0000, 8'd30, "R2");
        wr(4'h4, 32'h9A00_0000, 8'd30, "R2");
        wr(4'h0, 32'h1F00_0000, 8'd30, "R2");
        wr(4'h4, 32'h0100_0000, 8'd31, "R2");
        wr(4'h4, 32'h0200_0000, 8'd31, "R2");
        wr(4'h4, 32'h0300_0000, 8'd31, "R2");
        look(8'd30, "R2");
        look(8'd31, "R2");

        // R7 reset mid-run: contents, index and state cleared
        wr(4'h0, 32'h4000_0000, 8'd0, "R7");
        wr(4'h4, 32'h5500_0000, 8'd0, "R7");
        look(8'd0, "R7");
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look(8'd31,  "R7");
        look(8'd255, "R7");
        wr(4'h4, 32'h7700_0000, 8'd0, "R7");
        wr(4'h4, 32'h8800_0000, 8'd0, "R7");
        wr(4'h4, 32'h9900_0000, 8'd0, "R7");
        look(8'd0,  "R7");
        look(8'd64, "R7");
        look(8'd1,  "R7");
        look(8'd1,  "R7");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending results: got %0d expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule